// File: doc/BRIEF.md
# Write-Once Nonvolatile Timing Clock Divider

This block derives the slow timing base used by a nonvolatile memory controller from the bus clock. Software programs one 8-bit register through a plain strobe-based read/write port. The low seven bits hold the divider setting: a 6-bit divisor value and a prescaler select. These bits accept exactly one write after reset. The top bit is a read-only flag that reports whether that write has happened.

The divider does not create a new clock net. It produces a one-bus-cycle enable, `fclk_tick`, once per divided period. Erase and program sequencers count these ticks to time their pulses. Until the register has been loaded, the counters are held at zero, no tick is produced and `pgm_permit` stays low. This blocks every erase and program operation. A combinational range flag compares the programmed division against the bus frequency parameter. It reports settings whose divided rate falls outside the allowed 150 kHz to 200 kHz window.

Top module: `nvm_tick_divider`

## Requirements
- R1: After reset, bit 7 of the register reads 0. The first write after reset sets it to 1 whatever data that write carries, including 0x00.
- R2: Bits 6:0 take the value of the first write after reset only. Every later write is ignored: the read-back value and the tick period stay unchanged.
- R3: `pgm_permit` is 0 and `fclk_tick` never pulses while bit 7 is 0. `pgm_permit` is 1 and stays 1 from the cycle after the first write until reset.
- R4: Bit 6 selects the prescaler. When it is 1, the divided period is 8×(DIV+1) bus cycles. When it is 0, the period is DIV+1 bus cycles, where DIV is bits 5:0.
- R5: Let the loading write be sampled at clock edge E, and let P be the period from R4. The first tick is high in the cycle that follows edge E+P−1, and ticks then repeat every P cycles.
- R6: While `reg_rd` is 1, `reg_rdata` shows {bit 7 flag, bit 6 prescaler select, bits 5:0 DIV} in the same cycle. While `reg_rd` is 0, `reg_rdata` is 0x00.
- R7: `rate_bad` is 1 exactly when BUS_HZ/P lies outside the inclusive range 150000 to 200000. It is evaluated on the current register contents, so after reset P=1. With the default 4 MHz bus, P=20 through 26 are in range and P=19 and P=27 are not.
- R8: When P is greater than 1, each tick is high for exactly one bus cycle. When P equals 1, the tick is high in every cycle once loaded.
- R9: All register bits reset to 0, so a read right after reset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data; bit 6 is the prescaler select, bits 5:0 are DIV, bit 7 is ignored |
| reg_rdata | output | 8 | Combinational read data |
| fclk_tick | output | 1 | One-cycle enable, once per divided period |
| pgm_permit | output | 1 | High when erase and program operations are allowed |
| rate_bad | output | 1 | Programmed rate is outside the 150 kHz to 200 kHz window |

## Verification
The divider is exercised with several settings:
- Plain divisors of 20 and 1 separate the no-prescaler path from the degenerate always-high tick.
- Prescaled settings with DIV=2 and DIV=0 show that bit 6 multiplies the period by eight.
- A second write after loading with different data shows that the lock holds, both in the read-back value and in the measured tick gap.
- A divisor of 0x00 shows that the flag depends on the write strobe and not on the data.
- Divisors of 19, 20, 26 and 27 place the range flag on both edges of the frequency window.

// File: rtl/nvmdiv_pkg.sv
package nvmdiv_pkg;

   // Register layout: [7] loaded flag, [6] prescaler select, [5:0] divisor
   localparam int unsigned NVD_REG_W = 8;
   localparam int unsigned NVD_DIV_W = NVD_REG_W - 2;

   typedef struct packed {
      logic                 pre;
      logic [NVD_DIV_W-1:0] div;
   } nvd_cfg_t;

   localparam int unsigned NVD_CFG_W = $bits(nvd_cfg_t);

endpackage

// File: rtl/nvmdiv_cfg_reg.sv
module nvmdiv_cfg_reg
   import nvmdiv_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  logic                 rd_stb,
   input  logic [NVD_REG_W-1:0] wdata,
   output logic [NVD_REG_W-1:0] rdata,
   output nvd_cfg_t             cfg,
   output logic                 loaded
);

   logic take_write;

   assign take_write = wr_stb && !loaded;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded <= 1'b0;
         cfg    <= '0;
      end else if (take_write) begin
         loaded <= 1'b1;
         cfg    <= nvd_cfg_t'(wdata[NVD_CFG_W-1:0]);
      end
   end

   assign rdata = rd_stb ? {loaded, cfg} : '0;

   AST_FLAG_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !loaded) |=> loaded);                                // R1

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |=> (loaded && $stable(cfg)));                           // R2

endmodule

// File: rtl/nvmdiv_tick_gen.sv
module nvmdiv_tick_gen
   import nvmdiv_pkg::*;
#(
   parameter int unsigned PRE_LOG2 = 3
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  nvd_cfg_t cfg,
   output logic     tick
);

   logic                 pre_wrap;
   logic                 pre_active;
   logic [NVD_DIV_W-1:0] div_cnt;
   logic                 div_wrap;
   logic                 unit_period;

   generate
      if (PRE_LOG2 == 0) begin : g_no_pre
         assign pre_wrap   = 1'b1;
         assign pre_active = 1'b0;
      end else begin : g_pre
         logic [PRE_LOG2-1:0] pre_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_cnt <= '0;
            end else if (!run || !cfg.pre) begin
               pre_cnt <= '0;
            end else begin
               pre_cnt <= pre_cnt + 1'b1;
            end
         end

         assign pre_active = cfg.pre;
         assign pre_wrap   = !cfg.pre || (&pre_cnt);
      end
   endgenerate

   assign div_wrap = (div_cnt == cfg.div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (!run) begin
         div_cnt <= '0;
      end else if (pre_wrap) begin
         div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      end
   end

   assign tick        = run && pre_wrap && div_wrap;
   assign unit_period = (cfg.div == '0) && !pre_active;

   AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);                                                // R3

   AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (div_cnt <= cfg.div));                                  // R5

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !unit_period) |=> !tick);                              // R8

endmodule

// File: rtl/nvmdiv_rate_chk.sv
module nvmdiv_rate_chk
   import nvmdiv_pkg::*;
#(
   parameter int unsigned PRE_LOG2 = 3,
   parameter int unsigned BUS_HZ   = 4_000_000,
   parameter int unsigned LO_HZ    = 150_000,
   parameter int unsigned HI_HZ    = 200_000
)(
   input  nvd_cfg_t cfg,
   output logic     rate_bad
);

   localparam int unsigned N_W = NVD_DIV_W + 1 + PRE_LOG2;
   localparam logic [63:0] BUS_64 = 64'(BUS_HZ);
   localparam logic [63:0] LO_64  = 64'(LO_HZ);
   localparam logic [63:0] HI_64  = 64'(HI_HZ);

   logic [N_W-1:0] base_n;
   logic [N_W-1:0] total_n;
   logic [63:0]    lo_bound;
   logic [63:0]    hi_bound;

   assign base_n = N_W'(cfg.div) + N_W'(1);

   generate
      if (PRE_LOG2 == 0) begin : g_no_pre
         assign total_n = base_n;
      end else begin : g_pre
         assign total_n = cfg.pre ? (base_n << PRE_LOG2) : base_n;
      end
   endgenerate

   // BUS/n < LO  <=>  BUS < LO*n ;  BUS/n > HI  <=>  BUS > HI*n
   assign lo_bound = LO_64 * 64'(total_n);
   assign hi_bound = HI_64 * 64'(total_n);
   assign rate_bad = (BUS_64 < lo_bound) || (BUS_64 > hi_bound);

endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider
   import nvmdiv_pkg::*;
#(
   parameter int unsigned PRE_LOG2 = 3,
   parameter int unsigned BUS_HZ   = 4_000_000,
   parameter int unsigned LO_HZ    = 150_000,
   parameter int unsigned HI_HZ    = 200_000
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [NVD_REG_W-1:0] reg_wdata,
   output logic [NVD_REG_W-1:0] reg_rdata,
   output logic                 fclk_tick,
   output logic                 pgm_permit,
   output logic                 rate_bad
);

   initial begin
      assert (PRE_LOG2 <= 8) else $error("PRE_LOG2 too large");
      assert (LO_HZ > 0 && LO_HZ < HI_HZ) else $error("bad frequency window");
      assert (BUS_HZ > 0) else $error("BUS_HZ must be nonzero");
   end

   nvd_cfg_t cfg;
   logic     loaded;

   nvmdiv_cfg_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (reg_wr),
      .rd_stb (reg_rd),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .cfg    (cfg),
      .loaded (loaded)
   );

   nvmdiv_tick_gen #(.PRE_LOG2(PRE_LOG2)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (loaded),
      .cfg   (cfg),
      .tick  (fclk_tick)
   );

   nvmdiv_rate_chk #(
      .PRE_LOG2 (PRE_LOG2),
      .BUS_HZ   (BUS_HZ),
      .LO_HZ    (LO_HZ),
      .HI_HZ    (HI_HZ)
   ) u_rate (
      .cfg      (cfg),
      .rate_bad (rate_bad)
   );

   assign pgm_permit = loaded;

   AST_PERMIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_permit |=> pgm_permit);                                     // R3

   AST_UNLOADED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !pgm_permit) |-> (reg_rdata == '0));                 // R9

endmodule

// File: tb/nvm_tick_divider_test.sv
module nvm_tick_divider_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       fclk_tick;
   logic       pgm_permit;
   logic       rate_bad;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   nvm_tick_divider uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .fclk_tick  (fclk_tick),
      .pgm_permit (pgm_permit),
      .rate_bad   (rate_bad)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Returns in the first cycle after the write edge (cycle index 0).
   task automatic write_reg(input logic [7:0] d);
      reg_wr    = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = 8'h00;
   endtask

   task automatic read_reg(output logic [7:0] d);
      reg_rd = 1'b1;
      #1 d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   // Called at cycle index 0 after the loading write.
   task automatic check_ticks(input int p, input string req);
      int first = -1;
      int second = -1;
      int after_first = 0;
      for (int j = 0; j < 2 * p + 2; j++) begin
         if (fclk_tick) begin
            if (first < 0) first = j;
            else if (second < 0) second = j;
         end
         if (j == p) after_first = fclk_tick;
         @(negedge clk);
      end
      chk(first == p - 1, req, "first tick index", first, p - 1);
      chk(second == 2 * p - 1, req, "second tick index", second, 2 * p - 1);
      if (p > 1) chk(after_first == 0, "R8", "tick width", after_first, 0);
   endtask

   task automatic measure_gap(input int p, input string req);
      int gap = 0;
      int k = 0;
      while (!fclk_tick && k < 1000) begin @(negedge clk); k++; end
      @(negedge clk);
      while (!fclk_tick && gap < 1000) begin @(negedge clk); gap++; end
      chk(gap + 1 == p, req, "tick gap", gap + 1, p);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      int ticks = 0;
      do_reset();
      read_reg(d);
      chk(d == 8'h00, "R9", "reset read", d, 0);
      chk(d[7] == 1'b0, "R1", "flag after reset", d[7], 0);
      chk(pgm_permit == 1'b0, "R3", "permit after reset", pgm_permit, 0);
      for (int i = 0; i < 40; i++) begin
         ticks += fclk_tick;
         @(negedge clk);
      end
      chk(ticks == 0, "R3", "ticks while unloaded", ticks, 0);
      chk(rate_bad == 1'b1, "R7", "rate flag with P=1", rate_bad, 1);
   endtask

   task automatic t_plain();
      logic [7:0] d;
      do_reset();
      write_reg(8'h13);
      chk(pgm_permit == 1'b1, "R3", "permit after load", pgm_permit, 1);
      check_ticks(20, "R5");
      read_reg(d);
      chk(d == 8'h93, "R6", "read after load", d, 8'h93);
      chk(d[7] == 1'b1, "R1", "flag after load", d[7], 1);
      chk(rate_bad == 1'b0, "R7", "P=20 edge", rate_bad, 0);
      #1 chk(reg_rdata == 8'h00, "R6", "rdata with rd low", reg_rdata, 0);
   endtask

   task automatic t_prescale_and_lock();
      logic [7:0] d;
      do_reset();
      write_reg(8'h42);
      check_ticks(24, "R4");
      read_reg(d);
      chk(d == 8'hC2, "R4", "prescale read", d, 8'hC2);
      chk(rate_bad == 1'b0, "R7", "P=24", rate_bad, 0);
      write_reg(8'h05);
      read_reg(d);
      chk(d == 8'hC2, "R2", "second write ignored", d, 8'hC2);
      measure_gap(24, "R2");
      chk(rate_bad == 1'b0, "R2", "rate flag unchanged", rate_bad, 0);
   endtask

   task automatic t_prescale_div0();
      do_reset();
      write_reg(8'h40);
      check_ticks(8, "R4");
      chk(rate_bad == 1'b1, "R7", "P=8", rate_bad, 1);
   endtask

   task automatic t_zero_data();
      logic [7:0] d;
      int highs = 0;
      do_reset();
      write_reg(8'h00);
      for (int i = 0; i < 10; i++) begin
         highs += fclk_tick;
         @(negedge clk);
      end
      chk(highs == 10, "R8", "P=1 tick always high", highs, 10);
      read_reg(d);
      chk(d == 8'h80, "R1", "flag from zero data", d, 8'h80);
      chk(pgm_permit == 1'b1, "R3", "permit from zero data", pgm_permit, 1);
   endtask

   task automatic t_range(input logic [7:0] d, input bit exp_bad);
      do_reset();
      write_reg(d);
      chk(rate_bad == exp_bad, "R7", $sformatf("rate flag for 0x%0h", d),
          rate_bad, exp_bad);
   endtask

   initial begin
      t_reset();
      t_plain();
      t_prescale_and_lock();
      t_prescale_div0();
      t_zero_data();
      t_range(8'h12, 1'b1);   // P=19
      t_range(8'h19, 1'b0);   // P=26
      t_range(8'h1A, 1'b1);   // P=27
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule